// File: doc/BRIEF.md
# Four-Way Cache Tag and Replacement Controller

This block holds the tag and line state for a small data cache addressed by 12-bit byte addresses. Each cycle it may take one request, made of an address and a read/write flag. One cycle later it answers with a classification. The answer is a hit, a cold miss that fills an empty way, or an evicting miss that displaces a valid line. An evicting miss also reports the displaced line's tag and whether that line was dirty, so a surrounding controller can schedule a write-back. The block holds no data bytes and runs no refill protocol. It decides where each line goes and keeps the bookkeeping bits for that placement.

The capacity equals a 16-line direct-mapped cache with 32-byte lines, which is 512 bytes. That capacity is arranged as 4 sets of 4 ways. The offset is bits 4-0, the set index is bits 6-5 and the tag is bits 11-7. A build-time parameter picks the replacement policy. One choice is true LRU, using a 2-bit age per way. The other is a 3-bit binary-tree pseudo-LRU per set.

The response is a small registered state machine with four named states: `RK_NONE` (no response), `RK_HIT`, `RK_COLD` and `RK_EVICT`. On every clock edge the register moves to the state that classifies the request presented in that cycle. With no request it moves to `RK_NONE`. Reset forces `RK_NONE`.

Top module: `settag_ctrl`

## Requirements
- R1: The address splits into a 5-bit offset (bits 4-0, ignored for lookup), a 2-bit set index (bits 6-5) and a 5-bit tag (bits 11-7). Two addresses in the same 32-byte block therefore hit the same line.
- R2: A request whose tag matches a valid way of its set answers `rsp_hit`=1 with that way on `rsp_way`. A tag is never held valid in two ways of one set.
- R3: A miss in a set with an invalid way fills the lowest-numbered invalid way. It answers `rsp_miss`=1 with `rsp_replace`=0, `rsp_victim_dirty`=0 and `rsp_victim_tag`=0.
- R4: With `USE_PLRU`=0, a miss in a full set evicts the least recently used way. It answers `rsp_replace`=1 and gives that way's old tag on `rsp_victim_tag`.
- R5: In LRU mode each way keeps a 2-bit age, and after reset way w has age w. A hit or fill sets the accessed way's age to 0 and adds one to every way in that set that was younger than it. The victim is the way with age 3.
- R6: With `USE_PLRU`=1 each set keeps a 3-bit tree: bit 0 selects the pair (0 means ways 0/1), bit 1 selects within ways 0/1 and bit 2 selects within ways 2/3. An access points the root bit and its pair bit away from the accessed way. The victim follows the bits, and reset clears them, so the victim starts at way 0.
- R7: A write sets the dirty bit of the line it hits or fills, and a read fill clears it. On an evicting miss, `rsp_victim_dirty` gives the evicted line's dirty bit.
- R8: The response appears in the cycle after the request: `rsp_valid` is 1 exactly when `req_valid` was 1 in the previous cycle. When `rsp_valid` is 1, exactly one of `rsp_hit` or `rsp_miss` is 1. `rsp_replace` is 1 only with `rsp_miss`.
- R9: A synchronous reset clears every valid bit, dirty bit and replacement state, and drops the response. The first access after reset to any address is a cold miss into way 0.
- R10: A cycle with `req_valid`=0 changes no line or replacement state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Byte address of the access |
| req_write | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Tag found in the set |
| rsp_miss | output | 1 | Tag not found; a line was allocated |
| rsp_replace | output | 1 | The miss displaced a valid line |
| rsp_victim_dirty | output | 1 | The displaced line was dirty |
| rsp_way | output | 2 | Way that was hit or filled |
| rsp_victim_tag | output | 5 | Tag of the displaced line |

## Verification
The bench builds two copies with the default 12-bit, 16-line, 4-way geometry: one with `USE_PLRU`=0 and one with `USE_PLRU`=1. Both receive the same stimulus. A directed recency pattern makes the two policies pick different victims, one of them dirty, so each policy's ordering shows up at the ports. The small geometry, with only 4 sets and a random tag range of 8 values per set, keeps sets full and evicting. This exercises LRU ageing, tree pointing and dirty write-back reporting thousands of times within a short run.

// File: rtl/settag_pkg.sv
package settag_pkg;
    typedef enum logic [1:0] {
        RK_NONE  = 2'd0,
        RK_HIT   = 2'd1,
        RK_COLD  = 2'd2,
        RK_EVICT = 2'd3
    } rsp_kind_e;
endpackage

// File: rtl/settag_lookup.sv
module settag_lookup #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int TAG_W = 5
) (
    input  logic [WAYS-1:0]       set_valid,
    input  logic [WAYS*TAG_W-1:0] set_tags,
    input  logic [TAG_W-1:0]      req_tag,
    output logic [WAYS-1:0]       hit_vec,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic                  free_any,
    output logic [WAY_W-1:0]      free_way
);
    // one comparator per way
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = set_valid[w] && (set_tags[w*TAG_W +: TAG_W] == req_tag);
    end

    assign hit      = |hit_vec;
    assign free_any = ~&set_valid;

    // lowest index wins for both encoders
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])    hit_way  = WAY_W'(w);
            if (!set_valid[w]) free_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/settag_lru.sv
module settag_lru #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int SET_W = 2,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [SET_W-1:0] qry_set,
    output logic [WAY_W-1:0] victim_way
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAYS-1:0]  oldest_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way)
                    age_q[upd_set][w] <= '0;
                else if (age_q[upd_set][w] < age_q[upd_set][upd_way])
                    age_q[upd_set][w] <= age_q[upd_set][w] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_way = '0;
        oldest_vec = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[qry_set][w] == OLDEST) begin
                oldest_vec[w] = 1'b1;
                victim_way    = WAY_W'(w);
            end
        end
    end

    // R5: the touched way is youngest right after its update
    p_touch_youngest_r5: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> age_q[$past(upd_set)][$past(upd_way)] == '0);

    // R4: ages stay a permutation, so exactly one way is the victim
    p_single_oldest_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1);
endmodule

// File: rtl/settag_plru.sv
module settag_plru #(
    parameter int SETS  = 4,
    parameter int SET_W = 2,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [SET_W-1:0] qry_set,
    output logic [WAY_W-1:0] victim_way
);
    // bit 0: pair select, bit 1: ways 0/1, bit 2: ways 2/3
    logic [2:0] tree_q [SETS];

    function automatic logic [WAY_W-1:0] walk(input logic [2:0] t);
        if (t[0]) return t[2] ? WAY_W'(3) : WAY_W'(2);
        else      return t[1] ? WAY_W'(1) : WAY_W'(0);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (upd_en) begin
            tree_q[upd_set][0] <= ~upd_way[1];
            if (upd_way[1]) tree_q[upd_set][2] <= ~upd_way[0];
            else            tree_q[upd_set][1] <= ~upd_way[0];
        end
    end

    assign victim_way = walk(tree_q[qry_set]);

    // R6: after an access the tree never points at the way just used
    p_points_away_r6: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> walk(tree_q[$past(upd_set)]) != $past(upd_way));
endmodule

// File: rtl/settag_ctrl.sv
module settag_ctrl
    import settag_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int OFFS_W   = 5,
    parameter int DM_LINES = 16,
    parameter int WAYS     = 4,
    parameter bit USE_PLRU = 1'b0,
    localparam int SETS    = DM_LINES / WAYS,
    localparam int SET_W   = $clog2(SETS),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int TAG_W   = ADDR_W - OFFS_W - SET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_replace,
    output logic              rsp_victim_dirty,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [TAG_W-1:0]  rsp_victim_tag
);
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];

    logic [SET_W-1:0] req_set;
    logic [TAG_W-1:0] req_tag;
    assign req_set = req_addr[OFFS_W +: SET_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

    logic [WAYS*TAG_W-1:0] set_tags;
    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w*TAG_W +: TAG_W] = tag_q[req_set][w];
    end

    logic [WAYS-1:0]  look_hit_vec;
    logic             look_hit, look_free;
    logic [WAY_W-1:0] look_hit_way, look_free_way, repl_way;

    settag_lookup #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_lookup (
        .set_valid (valid_q[req_set]),
        .set_tags  (set_tags),
        .req_tag   (req_tag),
        .hit_vec   (look_hit_vec),
        .hit       (look_hit),
        .hit_way   (look_hit_way),
        .free_any  (look_free),
        .free_way  (look_free_way)
    );

    rsp_kind_e        kind_d, kind_q;
    logic [WAY_W-1:0] acc_way;

    if (USE_PLRU) begin : g_plru
        settag_plru #(.SETS(SETS), .SET_W(SET_W), .WAY_W(WAY_W)) u_repl (
            .clk(clk), .rst(rst), .upd_en(req_valid), .upd_set(req_set),
            .upd_way(acc_way), .qry_set(req_set), .victim_way(repl_way)
        );
    end else begin : g_lru
        settag_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_repl (
            .clk(clk), .rst(rst), .upd_en(req_valid), .upd_set(req_set),
            .upd_way(acc_way), .qry_set(req_set), .victim_way(repl_way)
        );
    end

    // next-state classification and target way
    always_comb begin
        kind_d  = RK_NONE;
        acc_way = repl_way;
        if (req_valid) begin
            if (look_hit) begin
                kind_d  = RK_HIT;
                acc_way = look_hit_way;
            end else if (look_free) begin
                kind_d  = RK_COLD;
                acc_way = look_free_way;
            end else begin
                kind_d  = RK_EVICT;
            end
        end
    end

    // state register with its response payload
    logic [WAY_W-1:0] way_q;
    logic [TAG_W-1:0] vtag_q;
    logic             vdirty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= RK_NONE;
            way_q    <= '0;
            vtag_q   <= '0;
            vdirty_q <= 1'b0;
        end else begin
            kind_q   <= kind_d;
            way_q    <= acc_way;
            vtag_q   <= (kind_d == RK_EVICT) ? tag_q[req_set][acc_way] : '0;
            vdirty_q <= (kind_d == RK_EVICT) && dirty_q[req_set][acc_way];
        end
    end

    // line state arrays
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
            end
        end else if (req_valid) begin
            valid_q[req_set][acc_way] <= 1'b1;
            tag_q[req_set][acc_way]   <= req_tag;
            dirty_q[req_set][acc_way] <= look_hit ? (dirty_q[req_set][acc_way] | req_write)
                                                  : req_write;
        end
    end

    // output decode from the state
    always_comb begin
        rsp_valid   = 1'b0;
        rsp_hit     = 1'b0;
        rsp_miss    = 1'b0;
        rsp_replace = 1'b0;
        unique case (kind_q)
            RK_NONE:  ;
            RK_HIT:   begin rsp_valid = 1'b1; rsp_hit  = 1'b1; end
            RK_COLD:  begin rsp_valid = 1'b1; rsp_miss = 1'b1; end
            RK_EVICT: begin rsp_valid = 1'b1; rsp_miss = 1'b1; rsp_replace = 1'b1; end
            default:  ;
        endcase
    end

    assign rsp_way          = way_q;
    assign rsp_victim_tag   = vtag_q;
    assign rsp_victim_dirty = vdirty_q;

    p_resp_follows_req_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && !rst));

    p_hit_xor_miss_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_miss}) == 1);

    p_replace_on_miss_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_replace |-> rsp_miss);

    p_no_dup_tag_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $onehot0(look_hit_vec));

    p_fill_free_first_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !look_hit && look_free) |=> (rsp_miss && !rsp_replace));

    p_dirty_needs_evict_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_victim_dirty |-> rsp_replace);
endmodule

// File: tb/settag_ctrl_bench.sv
module settag_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic        req_write = 1'b0;

    logic       l_valid, l_hit, l_miss, l_rep, l_vd;
    logic [1:0] l_way;
    logic [4:0] l_vtag;
    logic       p_valid, p_hit, p_miss, p_rep, p_vd;
    logic [1:0] p_way;
    logic [4:0] p_vtag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    settag_ctrl #(.USE_PLRU(1'b0)) u_settag_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(l_valid), .rsp_hit(l_hit), .rsp_miss(l_miss), .rsp_replace(l_rep),
        .rsp_victim_dirty(l_vd), .rsp_way(l_way), .rsp_victim_tag(l_vtag)
    );

    settag_ctrl #(.USE_PLRU(1'b1)) u_settag_ctrl_plru (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(p_valid), .rsp_hit(p_hit), .rsp_miss(p_miss), .rsp_replace(p_rep),
        .rsp_victim_dirty(p_vd), .rsp_way(p_way), .rsp_victim_tag(p_vtag)
    );

    // reference state: index 0 = LRU copy, 1 = tree copy
    bit       m_valid [2][4][4];
    bit       m_dirty [2][4][4];
    int       m_tag   [2][4][4];
    int       m_age   [4][4];
    bit [2:0] m_tree  [4];

    logic       e_hit [2];
    logic       e_rep [2];
    logic       e_vd  [2];
    logic [1:0] e_way [2];
    logic [4:0] e_vtag[2];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < 2; v++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 4; w++) begin
                    m_valid[v][s][w] = 0;
                    m_dirty[v][s][w] = 0;
                    m_tag[v][s][w]   = 0;
                end
        for (int s = 0; s < 4; s++) begin
            m_tree[s] = 3'b000;
            for (int w = 0; w < 4; w++) m_age[s][w] = w;
        end
    endtask

    function automatic int tree_pick(input bit [2:0] t);
        if (t[0]) return t[2] ? 3 : 2;
        return t[1] ? 1 : 0;
    endfunction

    task automatic model_access(input int v, input logic [11:0] a, input logic wr);
        int s = int'(a[6:5]);
        int tg = int'(a[11:7]);
        int hw = -1;
        int fw = -1;
        int way;
        int old;
        e_hit[v] = 0; e_rep[v] = 0; e_vd[v] = 0; e_vtag[v] = '0;
        for (int w = 3; w >= 0; w--) begin
            if (m_valid[v][s][w] && m_tag[v][s][w] == tg) hw = w;
            if (!m_valid[v][s][w]) fw = w;
        end
        if (hw >= 0) begin
            way = hw;
            e_hit[v] = 1;
            m_dirty[v][s][way] = m_dirty[v][s][way] | wr;
        end else begin
            if (fw >= 0) way = fw;
            else begin
                way = 0;
                if (v == 0) begin
                    for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) way = w;
                end else way = tree_pick(m_tree[s]);
                e_rep[v]  = 1;
                e_vd[v]   = m_dirty[v][s][way];
                e_vtag[v] = 5'(m_tag[v][s][way]);
            end
            m_valid[v][s][way] = 1;
            m_tag[v][s][way]   = tg;
            m_dirty[v][s][way] = wr;
        end
        e_way[v] = 2'(way);
        if (v == 0) begin
            old = m_age[s][way];
            for (int w = 0; w < 4; w++) begin
                if (w == way) m_age[s][w] = 0;
                else if (m_age[s][w] < old) m_age[s][w]++;
            end
        end else begin
            m_tree[s][0] = ~way[1];
            if (way[1]) m_tree[s][2] = ~way[0];
            else        m_tree[s][1] = ~way[0];
        end
    endtask

    function automatic string kind_tag(input int v);
        if (e_hit[v]) return "R2";
        if (!e_rep[v]) return "R3";
        return (v == 0) ? "R4" : "R6";
    endfunction

    // drive at a falling edge, check the response at the next falling edge
    task automatic access(input logic [11:0] a, input logic wr);
        string t0, t1;
        req_valid = 1'b1; req_addr = a; req_write = wr;
        model_access(0, a, wr);
        model_access(1, a, wr);
        t0 = kind_tag(0);
        t1 = kind_tag(1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8", "lru valid", int'(l_valid), 1);
        chk(t0, "lru hit", int'(l_hit), int'(e_hit[0]));
        chk("R8", "lru miss", int'(l_miss), int'(!e_hit[0]));
        chk(t0, "lru replace", int'(l_rep), int'(e_rep[0]));
        chk(t0, "lru way", int'(l_way), int'(e_way[0]));
        chk("R4", "lru victim tag", int'(l_vtag), int'(e_vtag[0]));
        chk("R7", "lru victim dirty", int'(l_vd), int'(e_vd[0]));
        chk("R8", "plru valid", int'(p_valid), 1);
        chk(t1, "plru hit", int'(p_hit), int'(e_hit[1]));
        chk(t1, "plru replace", int'(p_rep), int'(e_rep[1]));
        chk(t1, "plru way", int'(p_way), int'(e_way[1]));
        chk("R6", "plru victim tag", int'(p_vtag), int'(e_vtag[1]));
        chk("R7", "plru victim dirty", int'(p_vd), int'(e_vd[1]));
    endtask

    task automatic idle_cycle();
        req_valid = 1'b0;
        @(negedge clk);
        chk("R10", "lru idle valid", int'(l_valid), 0);
        chk("R10", "plru idle valid", int'(p_valid), 0);
    endtask

    task automatic do_reset();
        req_valid = 1'b0;
        rst = 1'b1;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R9", "lru valid after reset", int'(l_valid), 0);
        chk("R9", "plru valid after reset", int'(p_valid), 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] seq [11];
        seq = '{12'hf48, 12'hf58, 12'hdc4, 12'h44c, 12'hdb4, 12'hdac,
                12'hee4, 12'hf30, 12'hf40, 12'h84c, 12'h1cd};
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R1: 0xf48 and 0xf58 share a block (set 2, tag 0x1e)
        access(seq[0], 1'b0);
        chk("R1", "first access cold way", int'(l_way), 0);
        access(seq[1], 1'b0);
        chk("R1", "same block hit", int'(l_hit), 1);
        for (int i = 2; i < 11; i++) access(seq[i], 1'b0);

        // R4/R6/R7: policies disagree on the victim
        do_reset();
        for (int t = 0; t < 4; t++) access(12'(t << 7), 1'b0);
        access(12'(1 << 7) | 12'h004, 1'b1);
        access(12'h010, 1'b0);
        access(12'(4 << 7), 1'b0);
        chk("R4", "lru evicts oldest way", int'(l_way), 2);
        chk("R6", "tree evicts way", int'(p_way), 2);
        access(12'(5 << 7), 1'b0);
        chk("R4", "lru next victim tag", int'(l_vtag), 3);
        chk("R7", "tree picks dirty line", int'(p_vd), 1);

        // R10: idle cycles leave state alone
        idle_cycle();
        idle_cycle();
        access(12'(5 << 7), 1'b0);
        chk("R10", "line kept over idle", int'(l_hit), 1);

        // random traffic on a narrow tag range
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] a;
            a = {2'b00, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 5'($urandom)};
            if ($urandom_range(0, 7) == 0) idle_cycle();
            else access(a, 1'($urandom_range(0, 1)));
        end

        // R9: reset in the middle of traffic
        do_reset();
        access(seq[0], 1'b0);
        chk("R9", "cold after reset", int'(l_hit), 0);
        chk("R9", "way 0 after reset", int'(p_way), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule